// File: doc/BRIEF.md
# USB Charge-Mode Control Sequencer

This block turns a three-bit charge-mode selection and a single enable input into the digital controls around a USB port power path. The controls are the power-switch enable, the output-discharge enable, the data-line pass-switch enable, and a one-hot flag that names the active port personality. The personalities are standard host port, charging host port, and three dedicated-charger submodes: auto-detect, battery-charging-spec only, and resistor-divider only. A build parameter picks one of two mode tables. In the first table, code 000 is a forced power-off-and-discharge state. In the second table, a low enable also discharges the output.

The selection and enable inputs are first passed through a synchronizer. A new value is taken only after it has held steady for a set number of clocks. When an accepted change moves the port into or out of either host personality, the block runs a renegotiation sequence on VBUS. It opens the power switch and turns on the discharge path. It then waits for a sampled "output below threshold" flag. After that it counts a fixed number of millisecond ticks and only then closes the power switch again. The analog side, the current limit and the charger handshake itself are outside this block. The block only reports which dedicated-charger submode is requested.

Top module: `usb_chg_mode_seq`

## Requirements
- R1: While reset is held, and until the first value is accepted, pwrOn, dischargeOn and dataSwOn are 0 and modeOneHot is 0.
- R2: {modeCode, enableIn} passes a two-flop synchronizer and is accepted only after it has been steady for STABLE_CYCLES (default 4) clocks. A change that lasts two clocks has no effect on any output.
- R3: With VARIANT_B=0, modeCode bits [2:0] decode as follows: 000 = off, 0x1 = dedicated auto-detect, x10 = standard host, 100 = dedicated spec-only, 101 = dedicated divider-only, 111 = charging host. The modeOneHot bits are: bit0 standard host, bit1 charging host, bit2 dedicated auto-detect, bit3 dedicated spec-only, bit4 dedicated divider-only. The off state shows all zeros.
- R4: With VARIANT_B=1, modeCode decodes as follows: 00x = dedicated auto-detect, 01x = dedicated spec-only, 10x = dedicated divider-only, 110 = standard host, 111 = charging host. It uses the same modeOneHot bits as R3.
- R5: With VARIANT_B=0 and code 000 accepted, pwrOn=0, dischargeOn=1 and dataSwOn=0.
- R6: With enableIn low, pwrOn=0 and dataSwOn=0. For VARIANT_B=0, dischargeOn=0 (except under code 000). For VARIANT_B=1, dischargeOn=1.
- R7: dataSwOn is 1 exactly when the mode is standard host or charging host and enable is high. In dedicated modes with enable high, pwrOn=1 and dataSwOn=0.
- R8: The first accepted value after reset enters its mode directly, with no discharge sequence.
- R9: If an accepted mode change has a host personality as its old or new mode, the following happens. pwrOn drops and dischargeOn rises. This holds until vbusLow has been seen. Then REAPPLY_TICKS msTick pulses are counted, after which pwrOn=1 and dischargeOn=0.
- R10: These changes run no discharge sequence: a change between dedicated submodes, a change between two codes of the same mode, and a change of enable alone.
- R11: A qualifying change that arrives during a sequence restarts it. The tick count is cleared and vbusLow must be seen again.
- R12: pwrOn and dischargeOn are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeCode | input | 3 | Charge-mode selection, asynchronous |
| enableIn | input | 1 | Enable (variant B: low also discharges), asynchronous |
| vbusLow | input | 1 | Sampled flag: output is below the discharge threshold |
| msTick | input | 1 | One-cycle pulse per millisecond |
| pwrOn | output | 1 | Power-switch enable |
| dischargeOn | output | 1 | Output-discharge enable |
| dataSwOn | output | 1 | Data-line pass-switch enable |
| modeOneHot | output | 5 | Active mode, one-hot per R3 |

## Verification
The hardest state to reach from the ports is a restart in the middle of a sequence. The tick counter must already be partly advanced, and the threshold flag must have been released, when a second host-related change is accepted. The stimulus starts a host transition and lets a few ticks count. It then drops vbusLow and applies another qualifying code. After that it shows that extra ticks do not restore power until the threshold is seen again and the full count is repeated. Glitch rejection is reached by holding a new code for fewer clocks than the filter needs and confirming the outputs never move.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  localparam int ONEHOT_W = 5;

  typedef enum logic [2:0] {
    CM_OFF,
    CM_SDP,
    CM_CDP,
    CM_DCP_AUTO,
    CM_DCP_BC,
    CM_DCP_DIV
  } chgMode_e;

  // control -> datapath
  typedef struct packed {
    logic timerClr;
    logic timerInc;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       accStrobe;
    logic [2:0] accCode;
    logic       accEn;
    logic       timerDone;
  } dpStatus_t;

  function automatic chgMode_e decodeMode(input logic variantB, input logic [2:0] code);
    chgMode_e m;
    if (!variantB) begin
      // bit2..bit0 = selection bits, table with a forced-off code
      if (code == 3'b000)                 m = CM_OFF;
      else if (!code[2] && code[0])       m = CM_DCP_AUTO;
      else if (code[1] && !code[0])       m = CM_SDP;
      else if (code == 3'b100)            m = CM_DCP_BC;
      else if (code == 3'b101)            m = CM_DCP_DIV;
      else                                m = CM_CDP;
    end else begin
      case (code[2:1])
        2'b00:   m = CM_DCP_AUTO;
        2'b01:   m = CM_DCP_BC;
        2'b10:   m = CM_DCP_DIV;
        default: m = code[0] ? CM_CDP : CM_SDP;
      endcase
    end
    return m;
  endfunction

  function automatic logic [ONEHOT_W-1:0] toOneHot(input chgMode_e m);
    logic [ONEHOT_W-1:0] v;
    case (m)
      CM_SDP:      v = 5'b00001;
      CM_CDP:      v = 5'b00010;
      CM_DCP_AUTO: v = 5'b00100;
      CM_DCP_BC:   v = 5'b01000;
      CM_DCP_DIV:  v = 5'b10000;
      default:     v = 5'b00000;
    endcase
    return v;
  endfunction

  function automatic logic isHostMode(input chgMode_e m);
    return (m == CM_SDP) || (m == CM_CDP);
  endfunction

endpackage

// File: rtl/chg_seq_datapath.sv
module chg_seq_datapath
  import chg_seq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4,
  parameter int REAPPLY_TICKS = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeCode,
  input  logic       enableIn,
  input  seqStrobe_t stb,
  output dpStatus_t  st
);

  localparam int IN_W  = 4;
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam int TMR_W = $clog2(REAPPLY_TICKS + 1);

  logic [IN_W-1:0] rawIn;
  assign rawIn = {modeCode, enableIn};

  // synchronizer chain
  logic [SYNC_STAGES-1:0][IN_W-1:0] syncPipe;
  logic [IN_W-1:0] syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end
  assign syncOut = syncPipe[SYNC_STAGES-1];

  // stability filter
  logic [IN_W-1:0]  candVal;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candVal   <= '0;
      stableCnt <= '0;
    end else if (syncOut != candVal) begin
      candVal   <= syncOut;
      stableCnt <= CNT_W'(1);
    end else if (stableCnt < CNT_W'(STABLE_CYCLES)) begin
      stableCnt <= stableCnt + CNT_W'(1);
    end
  end

  // acceptance register
  logic [IN_W-1:0] accVal;
  logic            accValid;
  logic            acceptStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accVal       <= '0;
      accValid     <= 1'b0;
      acceptStrobe <= 1'b0;
    end else begin
      acceptStrobe <= 1'b0;
      if (stableCnt == CNT_W'(STABLE_CYCLES) && (!accValid || candVal != accVal)) begin
        accVal       <= candVal;
        accValid     <= 1'b1;
        acceptStrobe <= 1'b1;
      end
    end
  end

  // R2: an accepted value was already present at the synchronizer output earlier
  assert_accept_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptStrobe |-> ($past(syncOut, 2) == accVal && $past(syncOut, 3) == accVal));

  // reapply tick counter
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrDone;
  assign tmrDone = (tmrCnt == TMR_W'(REAPPLY_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       tmrCnt <= '0;
    else if (stb.timerClr)           tmrCnt <= '0;
    else if (stb.timerInc && !tmrDone) tmrCnt <= tmrCnt + TMR_W'(1);
  end

  // R9: counter stays inside its window
  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    tmrCnt <= TMR_W'(REAPPLY_TICKS));

  assign st.accStrobe = acceptStrobe;
  assign st.accCode   = accVal[3:1];
  assign st.accEn     = accVal[0];
  assign st.timerDone = tmrDone;

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
  import chg_seq_pkg::*;
#(
  parameter bit VARIANT_B = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStatus_t           st,
  input  logic                vbusLow,
  input  logic                msTick,
  output seqStrobe_t          stb,
  output logic                pwrOn,
  output logic                dischargeOn,
  output logic                dataSwOn,
  output logic [ONEHOT_W-1:0] modeOneHot
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_HOLD} seqState_e;

  seqState_e state, stateNext;
  chgMode_e  curMode, newMode;
  logic      curEn;

  assign newMode = decodeMode(VARIANT_B, st.accCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= CM_OFF;
      curEn   <= 1'b0;
    end else if (st.accStrobe) begin
      curMode <= newMode;
      curEn   <= st.accEn;
    end
  end

  logic hostChange;
  assign hostChange = st.accStrobe && (newMode != curMode) &&
                      (isHostMode(newMode) || isHostMode(curMode));

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (st.accStrobe) stateNext = S_RUN;
      S_RUN:   if (hostChange) stateNext = S_DRAIN;
      S_DRAIN: if (hostChange) stateNext = S_DRAIN;
               else if (vbusLow) stateNext = S_HOLD;
      S_HOLD:  if (hostChange) stateNext = S_DRAIN;
               else if (st.timerDone) stateNext = S_RUN;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign stb.timerClr = (stateNext == S_DRAIN) || (state == S_DRAIN);
  assign stb.timerInc = (state == S_HOLD) && msTick;

  logic started, seqActive, staticPwr, staticDis;
  assign started   = (state != S_IDLE);
  assign seqActive = (state == S_DRAIN) || (state == S_HOLD);
  assign staticPwr = curEn && !(!VARIANT_B && curMode == CM_OFF);
  assign staticDis = VARIANT_B ? !curEn : (curMode == CM_OFF);

  assign pwrOn       = started && staticPwr && !seqActive;
  assign dischargeOn = started && (staticDis || seqActive);
  assign dataSwOn    = started && curEn && isHostMode(curMode);
  assign modeOneHot  = toOneHot(curMode);

  assert_pwr_dis_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(pwrOn && dischargeOn));

  assert_data_host_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataSwOn |-> (modeOneHot[0] || modeOneHot[1]));

  assert_mode_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(modeOneHot));

  assert_drain_keeps_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DRAIN && !vbusLow) |=> !pwrOn);

  assert_first_entry_direct_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && st.accStrobe) |=> (state == S_RUN));

endmodule

// File: rtl/usb_chg_mode_seq.sv
module usb_chg_mode_seq
  import chg_seq_pkg::*;
#(
  parameter bit VARIANT_B     = 1'b0,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4,
  parameter int REAPPLY_TICKS = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeCode,
  input  logic       enableIn,
  input  logic       vbusLow,
  input  logic       msTick,
  output logic       pwrOn,
  output logic       dischargeOn,
  output logic       dataSwOn,
  output logic [4:0] modeOneHot
);

  seqStrobe_t stb;
  dpStatus_t  st;

  chg_seq_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_CYCLES(STABLE_CYCLES),
    .REAPPLY_TICKS(REAPPLY_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .modeCode(modeCode),
    .enableIn(enableIn),
    .stb     (stb),
    .st      (st)
  );

  chg_seq_ctrl #(
    .VARIANT_B(VARIANT_B)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .vbusLow    (vbusLow),
    .msTick     (msTick),
    .stb        (stb),
    .pwrOn      (pwrOn),
    .dischargeOn(dischargeOn),
    .dataSwOn   (dataSwOn),
    .modeOneHot (modeOneHot)
  );

endmodule

// File: tb/tb_usb_chg_mode_seq.sv
`timescale 1ns/1ps
module tb_usb_chg_mode_seq;

  localparam int RT = 5;
  localparam logic [4:0] OH_SDP = 5'b00001, OH_CDP = 5'b00010, OH_AUTO = 5'b00100,
                         OH_BC  = 5'b01000, OH_DIV = 5'b10000, OH_NONE = 5'b00000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeA = 3'b111, modeB = 3'b110;
  logic enA = 1'b1, enB = 1'b1;
  logic below = 1'b0, tick = 1'b0;
  logic pwrA, disA, dataA, pwrB, disB, dataB;
  logic [4:0] ohA, ohB;

  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  usb_chg_mode_seq #(.VARIANT_B(1'b0), .REAPPLY_TICKS(RT)) dut (
    .clk(clk), .rstN(rstN), .modeCode(modeA), .enableIn(enA), .vbusLow(below),
    .msTick(tick), .pwrOn(pwrA), .dischargeOn(disA), .dataSwOn(dataA), .modeOneHot(ohA));

  usb_chg_mode_seq #(.VARIANT_B(1'b1), .REAPPLY_TICKS(RT)) dutB (
    .clk(clk), .rstN(rstN), .modeCode(modeB), .enableIn(enB), .vbusLow(below),
    .msTick(tick), .pwrOn(pwrB), .dischargeOn(disB), .dataSwOn(dataB), .modeOneHot(ohB));

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chkA(input string req, input logic p, input logic d, input logic s, input logic [4:0] oh);
    chk(req, "A pwr", {7'd0, pwrA}, {7'd0, p});
    chk(req, "A dis", {7'd0, disA}, {7'd0, d});
    chk(req, "A data", {7'd0, dataA}, {7'd0, s});
    chk(req, "A mode", {3'd0, ohA}, {3'd0, oh});
  endtask

  task automatic chkB(input string req, input logic p, input logic d, input logic s, input logic [4:0] oh);
    chk(req, "B pwr", {7'd0, pwrB}, {7'd0, p});
    chk(req, "B dis", {7'd0, disB}, {7'd0, d});
    chk(req, "B data", {7'd0, dataB}, {7'd0, s});
    chk(req, "B mode", {3'd0, ohB}, {3'd0, oh});
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic applyA(input logic [2:0] c, input logic e);
    @(negedge clk); modeA = c; enA = e; waitN(12);
  endtask

  task automatic applyB(input logic [2:0] c, input logic e);
    @(negedge clk); modeB = c; enB = e; waitN(12);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic completeSeq();
    @(negedge clk); below = 1'b1; waitN(3);
    repeat (RT + 1) pulseTick();
    below = 1'b0; waitN(4);
  endtask

  function automatic logic [4:0] expA(input logic [2:0] c);
    case (c)
      3'b000: return OH_NONE;
      3'b001, 3'b011: return OH_AUTO;
      3'b010, 3'b110: return OH_SDP;
      3'b100: return OH_BC;
      3'b101: return OH_DIV;
      default: return OH_CDP;
    endcase
  endfunction

  function automatic logic [4:0] expB(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return OH_AUTO;
      3'b010, 3'b011: return OH_BC;
      3'b100, 3'b101: return OH_DIV;
      3'b110: return OH_SDP;
      default: return OH_CDP;
    endcase
  endfunction

  task automatic testReset();
    waitN(3);
    chkA("R1", 0, 0, 0, OH_NONE);
    chkB("R1", 0, 0, 0, OH_NONE);
    @(negedge clk); rstN = 1'b1;
    waitN(2);
    chkA("R1", 0, 0, 0, OH_NONE);
  endtask

  task automatic testFirstEntry();
    waitN(12);
    // first accepted value: host mode, power applied without vbusLow
    chkA("R8", 1, 0, 1, OH_CDP);
    chkB("R8", 1, 0, 1, OH_SDP);
  endtask

  task automatic testTableA();
    for (int c = 0; c < 8; c++) begin
      applyA(3'(c), 1'b1);
      completeSeq();
      if (c == 0) chkA("R5", 0, 1, 0, OH_NONE);
      else begin
        logic [4:0] oh;
        oh = expA(3'(c));
        chkA("R3", 1, 0, (oh == OH_SDP || oh == OH_CDP), oh);
      end
    end
  endtask

  task automatic testTableB();
    for (int c = 0; c < 8; c++) begin
      logic [4:0] oh;
      applyB(3'(c), 1'b1);
      completeSeq();
      oh = expB(3'(c));
      chkB("R4", 1, 0, (oh == OH_SDP || oh == OH_CDP), oh);
    end
    applyB(3'b111, 1'b0);
    chkB("R6", 0, 1, 0, OH_CDP);
    applyB(3'b111, 1'b1);
    chkB("R10", 1, 0, 1, OH_CDP);
  endtask

  task automatic testEnableA();
    applyA(3'b100, 1'b1);
    completeSeq();
    applyA(3'b100, 1'b0);
    chkA("R6", 0, 0, 0, OH_BC);
    applyA(3'b100, 1'b1);
    chkA("R7", 1, 0, 0, OH_BC);
  endtask

  task automatic testFilter();
    // in BC mode: 2-clock glitch to divider code is ignored
    @(negedge clk); modeA = 3'b101;
    waitN(2); modeA = 3'b100;
    waitN(12);
    chkA("R2", 1, 0, 0, OH_BC);
    // a real change is not yet visible after 4 clocks
    @(negedge clk); modeA = 3'b101;
    waitN(4);
    chkA("R2", 1, 0, 0, OH_BC);
    waitN(8);
    chkA("R2", 1, 0, 0, OH_DIV);
  endtask

  task automatic testNoSeq();
    applyA(3'b001, 1'b1);
    chkA("R10", 1, 0, 0, OH_AUTO);
    applyA(3'b010, 1'b1);
    completeSeq();
    applyA(3'b110, 1'b1);
    chkA("R10", 1, 0, 1, OH_SDP);
    applyA(3'b110, 1'b0);
    applyA(3'b110, 1'b1);
    chkA("R10", 1, 0, 1, OH_SDP);
  endtask

  task automatic testSequence();
    applyA(3'b111, 1'b1);
    chkA("R9", 0, 1, 1, OH_CDP);
    waitN(5);
    chkA("R9", 0, 1, 1, OH_CDP);
    @(negedge clk); below = 1'b1; waitN(3);
    chkA("R9", 0, 1, 1, OH_CDP);
    repeat (RT - 1) pulseTick();
    chkA("R9", 0, 1, 1, OH_CDP);
    pulseTick(); waitN(3);
    chkA("R9", 1, 0, 1, OH_CDP);
    below = 1'b0;
  endtask

  task automatic testRestart();
    applyA(3'b110, 1'b1);
    completeSeq();
    applyA(3'b111, 1'b1);
    @(negedge clk); below = 1'b1; waitN(3);
    repeat (3) pulseTick();
    below = 1'b0;
    applyA(3'b101, 1'b1);
    repeat (RT + 1) pulseTick();
    chkA("R11", 0, 1, 0, OH_DIV);
    @(negedge clk); below = 1'b1; waitN(3);
    repeat (RT - 1) pulseTick();
    chkA("R11", 0, 1, 0, OH_DIV);
    pulseTick(); waitN(3);
    chkA("R11", 1, 0, 0, OH_DIV);
    below = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  // R12 is also observed continuously at the ports
  always @(negedge clk) begin
    if (rstN && ((pwrA && disA) || (pwrB && disB))) begin
      nChk++; nFail++;
      $display("FAIL R12 pwr/dis overlap: got 1 expected 0");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testFirstEntry();
    testTableA();
    testTableB();
    testEnableA();
    testFilter();
    testNoSeq();
    testSequence();
    testRestart();
    finishRun();
  end

endmodule